// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Bank

This block holds the waiting operations of one functional unit in a dynamically scheduled pipeline. Decoded operations arrive in program order from an issue queue, one per cycle. Each is placed in a free station. Each source operand is either copied as a value from the register file or replaced by the tag of the station that will produce it. The destination register is then renamed to the tag of the new station, so only the most recent writer of a register is allowed to update it.

Stations whose two operands are both present compete for the dispatch port. The lowest-numbered ready station wins and hands its operation, operand values and immediate to the functional unit. A single result bus returns a tag and a value. Every station waiting on that tag captures the value in the same cycle. The register file accepts the value only where that tag is still the pending producer. The producing station becomes free again when its own tag appears on the bus.

Top module: `rsb_bank`

## Requirements
- R1: After reset every station is free, `iss_stall` and `disp_valid` are low, and every register reads value 0 with producer tag 0.
- R2: Station tags run from 1 to NUM_RS, with tag 0 meaning "no pending producer". An accepted operation takes the lowest-numbered free station, and its tag is the station index plus one.
- R3: `iss_stall` is high exactly when every station is busy. While it is high, an operation presented on the issue port is not accepted and changes no state.
- R4: At issue, a source register whose producer tag is 0 supplies its register value. A source with a nonzero producer tag makes the station wait on that tag.
- R5: A result broadcast loads its value into every busy station that waits on the broadcast tag, for either operand.
- R6: A station is offered for dispatch only when it is busy, holds both operands and has not been dispatched yet. Among such stations the lowest-numbered is offered. A station leaves dispatch after a cycle with `disp_ready` high, and stays offered while `disp_ready` is low.
- R7: If an operation issues in the same cycle that its source's producer tag is broadcast, the station takes the broadcast value directly and does not wait.
- R8: A broadcast writes a register only when the register's producer tag equals the broadcast tag, and then clears that producer tag. A register renamed to a later producer keeps its value.
- R9: An accepted operation sets its destination register's producer tag to the new station's tag. This takes precedence over a clear caused by a broadcast in the same cycle, while the broadcast value is still written.
- R10: A station becomes free on the cycle after its own tag is broadcast. The immediate captured at issue is delivered unchanged on `disp_imm`.
- R11: When `iss_use2` is low, the second operand counts as present and is dispatched as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue port holds an operation |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_use2 | input | 1 | Second source is needed |
| iss_imm | input | IMM_W | Immediate / address offset |
| iss_stall | output | 1 | No station free; operation not accepted |
| disp_valid | output | 1 | A ready station is offered |
| disp_ready | input | 1 | Functional unit takes the offered station |
| disp_tag | output | TAG_W | Tag of the offered station |
| disp_op | output | OP_W | Its operation code |
| disp_vj | output | DATA_W | First operand value |
| disp_vk | output | DATA_W | Second operand value |
| disp_imm | output | IMM_W | Immediate captured at issue |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Producer tag of the result |
| cdb_value | input | DATA_W | Result value |
| rd_addr | input | REG_W | Register file read address |
| rd_data | output | DATA_W | Register value at rd_addr |
| rd_qi | output | TAG_W | Pending producer tag of rd_addr |

## Verification
Issue and result broadcast can fall in the same cycle. The sharp cases are a new operation reading a source whose producer is being broadcast, and a new operation renaming a register whose older producer is being broadcast. A small register set, dense issue and a fixed-latency functional-unit stub make both collisions common. A behavioural model settles them by a fixed order: the issue reads the pre-edge state with a bypass, and the rename is applied after the broadcast write. The model's predicted dispatch values and register contents are compared with the ports every cycle.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   typedef enum logic [1:0] {
      SRC_FROM_REG = 2'd0,
      SRC_FROM_BUS = 2'd1,
      SRC_PENDING  = 2'd2
   } src_kind_e;

   function automatic int tag_width(input int stations);
      int w;
      w = 1;
      while ((1 << w) < stations + 1) w = w + 1;
      return w;
   endfunction

   function automatic int index_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/rsb_select.sv
module rsb_select #(
   parameter int N = 4,
   localparam int IDX_W = rsb_pkg::index_width(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
            any      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rsb_regstat.sv
module rsb_regstat #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   localparam int REG_W   = rsb_pkg::index_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rename_en,
   input  logic [REG_W-1:0]  rename_reg,
   input  logic [TAG_W-1:0]  rename_tag,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic [REG_W-1:0]  src1,
   input  logic [REG_W-1:0]  src2,
   output logic [DATA_W-1:0] s1_val,
   output logic [TAG_W-1:0]  s1_tag,
   output logic [DATA_W-1:0] s2_val,
   output logic [TAG_W-1:0]  s2_tag,
   input  logic [REG_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_qi
);
   import rsb_pkg::*;

   logic [DATA_W-1:0] val_q [NUM_REGS];
   logic [TAG_W-1:0]  qi_q  [NUM_REGS];
   src_kind_e         k1, k2;

   function automatic src_kind_e classify(input logic [TAG_W-1:0] qi,
                                          input logic bv,
                                          input logic [TAG_W-1:0] bt);
      if (qi == '0)             return SRC_FROM_REG;
      else if (bv && bt == qi)  return SRC_FROM_BUS;
      else                      return SRC_PENDING;
   endfunction

   always_comb begin
      k1 = classify(qi_q[src1], cdb_valid, cdb_tag);
      k2 = classify(qi_q[src2], cdb_valid, cdb_tag);
      unique case (k1)
         SRC_FROM_REG: begin s1_val = val_q[src1]; s1_tag = '0; end
         SRC_FROM_BUS: begin s1_val = cdb_value;   s1_tag = '0; end
         default:      begin s1_val = '0;          s1_tag = qi_q[src1]; end
      endcase
      unique case (k2)
         SRC_FROM_REG: begin s2_val = val_q[src2]; s2_tag = '0; end
         SRC_FROM_BUS: begin s2_val = cdb_value;   s2_tag = '0; end
         default:      begin s2_val = '0;          s2_tag = qi_q[src2]; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            val_q[r] <= '0;
            qi_q[r]  <= '0;
         end
      end else begin
         for (int r = 0; r < NUM_REGS; r++) begin
            if (cdb_valid && qi_q[r] != '0 && qi_q[r] == cdb_tag) begin
               val_q[r] <= cdb_value;
               qi_q[r]  <= '0;
            end
            if (rename_en && rename_reg == REG_W'(r))
               qi_q[r] <= rename_tag;
         end
      end
   end

   assign rd_data = val_q[rd_addr];
   assign rd_qi   = qi_q[rd_addr];

   p_rename_sets_qi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rename_en |=> qi_q[$past(rename_reg)] == $past(rename_tag));

   p_stale_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && qi_q[rd_addr] != cdb_tag)
      |=> val_q[$past(rd_addr)] == $past(val_q[rd_addr]));

   p_match_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && qi_q[rd_addr] != '0 && qi_q[rd_addr] == cdb_tag)
      |=> val_q[$past(rd_addr)] == $past(cdb_value));

endmodule

// File: rtl/rsb_station.sv
module rsb_station #(
   parameter int DATA_W = 32,
   parameter int OP_W   = 4,
   parameter int IMM_W  = 16,
   parameter int TAG_W  = 3,
   parameter int MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   a_op,
   input  logic [TAG_W-1:0]  a_qj,
   input  logic [DATA_W-1:0] a_vj,
   input  logic [TAG_W-1:0]  a_qk,
   input  logic [DATA_W-1:0] a_vk,
   input  logic [IMM_W-1:0]  a_imm,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic              grant,
   output logic              busy,
   output logic              ready,
   output logic [OP_W-1:0]   e_op,
   output logic [DATA_W-1:0] e_vj,
   output logic [DATA_W-1:0] e_vk,
   output logic [IMM_W-1:0]  e_imm
);

   localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

   logic              busy_q, sent_q;
   logic [OP_W-1:0]   op_q;
   logic [TAG_W-1:0]  qj_q, qk_q;
   logic [DATA_W-1:0] vj_q, vk_q;
   logic [IMM_W-1:0]  imm_q;
   logic              hit_own, hit_j, hit_k;

   assign hit_own = cdb_valid && cdb_tag == OWN_TAG;
   assign hit_j   = busy_q && cdb_valid && qj_q != '0 && qj_q == cdb_tag;
   assign hit_k   = busy_q && cdb_valid && qk_q != '0 && qk_q == cdb_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sent_q <= 1'b0;
         op_q   <= '0;
         qj_q   <= '0;
         qk_q   <= '0;
         vj_q   <= '0;
         vk_q   <= '0;
         imm_q  <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1;
         sent_q <= 1'b0;
         op_q   <= a_op;
         qj_q   <= a_qj;
         qk_q   <= a_qk;
         vj_q   <= a_vj;
         vk_q   <= a_vk;
         imm_q  <= a_imm;
      end else if (busy_q) begin
         if (hit_own) busy_q <= 1'b0;
         if (hit_j) begin
            vj_q <= cdb_value;
            qj_q <= '0;
         end
         if (hit_k) begin
            vk_q <= cdb_value;
            qk_q <= '0;
         end
         if (grant) sent_q <= 1'b1;
      end
   end

   assign busy  = busy_q;
   assign ready = busy_q && !sent_q && qj_q == '0 && qk_q == '0;
   assign e_op  = op_q;
   assign e_vj  = vj_q;
   assign e_vk  = vk_q;
   assign e_imm = imm_q;

   p_free_on_own_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && hit_own) |=> !busy_q);

   p_single_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !ready);

   p_capture_j_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_j |=> (qj_q == '0 && vj_q == $past(cdb_value)));

   p_capture_k_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_k |=> (qk_q == '0 && vk_q == $past(cdb_value)));

endmodule

// File: rtl/rsb_bank.sv
module rsb_bank #(
   parameter int NUM_RS   = 4,
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int OP_W     = 4,
   parameter int IMM_W    = 16,
   localparam int TAG_W   = rsb_pkg::tag_width(NUM_RS),
   localparam int REG_W   = rsb_pkg::index_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [REG_W-1:0]  iss_dst,
   input  logic [REG_W-1:0]  iss_src1,
   input  logic [REG_W-1:0]  iss_src2,
   input  logic              iss_use2,
   input  logic [IMM_W-1:0]  iss_imm,
   output logic              iss_stall,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [TAG_W-1:0]  disp_tag,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_vj,
   output logic [DATA_W-1:0] disp_vk,
   output logic [IMM_W-1:0]  disp_imm,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic [REG_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_qi
);

   localparam int IDX_W = rsb_pkg::index_width(NUM_RS);

   generate
      if (NUM_RS < 2)              begin : g_bad_rs   $error("NUM_RS must be at least 2"); end
      if ((1 << REG_W) != NUM_REGS) begin : g_bad_regs $error("NUM_REGS must be a power of two"); end
      if (DATA_W < 1 || OP_W < 1 || IMM_W < 1) begin : g_bad_w $error("widths must be positive"); end
   endgenerate

   logic [NUM_RS-1:0] busy_vec, ready_vec, free_vec;
   logic [NUM_RS-1:0] alloc_pick, alloc_vec, disp_pick, grant_vec;
   logic [IDX_W-1:0]  alloc_idx, disp_idx;
   logic              alloc_any, accept;
   logic [TAG_W-1:0]  alloc_tag;

   logic [DATA_W-1:0] s1_val, s2_val, a_vk;
   logic [TAG_W-1:0]  s1_tag, s2_tag, a_qk;

   logic [OP_W-1:0]   e_op  [NUM_RS];
   logic [DATA_W-1:0] e_vj  [NUM_RS];
   logic [DATA_W-1:0] e_vk  [NUM_RS];
   logic [IMM_W-1:0]  e_imm [NUM_RS];

   // issue side
   assign free_vec  = ~busy_vec;
   assign iss_stall = &busy_vec;
   assign accept    = iss_valid && !iss_stall;

   rsb_select #(.N(NUM_RS)) u_alloc_sel (
      .req(free_vec), .grant(alloc_pick), .idx(alloc_idx), .any(alloc_any));

   assign alloc_vec = alloc_pick & {NUM_RS{accept}};
   assign alloc_tag = TAG_W'(alloc_idx) + TAG_W'(1);

   rsb_regstat #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regstat (
      .clk(clk), .rst_n(rst_n),
      .rename_en(accept), .rename_reg(iss_dst), .rename_tag(alloc_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .src1(iss_src1), .src2(iss_src2),
      .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_qi(rd_qi));

   assign a_vk = iss_use2 ? s2_val : '0;
   assign a_qk = iss_use2 ? s2_tag : '0;

   // station array
   generate
      for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
         rsb_station #(
            .DATA_W(DATA_W), .OP_W(OP_W), .IMM_W(IMM_W),
            .TAG_W(TAG_W), .MY_TAG(i + 1)
         ) u_station (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc_vec[i]),
            .a_op(iss_op), .a_qj(s1_tag), .a_vj(s1_val),
            .a_qk(a_qk), .a_vk(a_vk), .a_imm(iss_imm),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
            .grant(grant_vec[i]),
            .busy(busy_vec[i]), .ready(ready_vec[i]),
            .e_op(e_op[i]), .e_vj(e_vj[i]), .e_vk(e_vk[i]), .e_imm(e_imm[i]));
      end
   endgenerate

   // dispatch side
   rsb_select #(.N(NUM_RS)) u_disp_sel (
      .req(ready_vec), .grant(disp_pick), .idx(disp_idx), .any(disp_valid));

   assign grant_vec = disp_pick & {NUM_RS{disp_ready}};
   assign disp_tag  = TAG_W'(disp_idx) + TAG_W'(1);

   always_comb begin
      disp_op  = '0;
      disp_vj  = '0;
      disp_vk  = '0;
      disp_imm = '0;
      for (int i = 0; i < NUM_RS; i++) begin
         if (disp_pick[i]) begin
            disp_op  = disp_op  | e_op[i];
            disp_vj  = disp_vj  | e_vj[i];
            disp_vk  = disp_vk  | e_vk[i];
            disp_imm = disp_imm | e_imm[i];
         end
      end
   end

   logic cdb_owner_busy;
   always_comb begin
      cdb_owner_busy = 1'b0;
      for (int i = 0; i < NUM_RS; i++)
         if (cdb_tag == TAG_W'(i + 1) && busy_vec[i]) cdb_owner_busy = 1'b1;
   end

   p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

   p_offer_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready && !cdb_valid) |=> disp_valid);

   p_full_blocks_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_stall && !cdb_valid) |=> $stable(busy_vec));

   p_bus_owner_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |-> cdb_owner_busy);

   p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> alloc_any);

endmodule

// File: tb/rsb_bank_bench.sv
module rsb_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NRS  = 4;
   localparam int NREG = 8;
   localparam int DW   = 32;
   localparam int OPW  = 4;
   localparam int IMMW = 16;
   localparam int TW   = 3;
   localparam int RW   = 3;
   localparam int LAT  = 3;
   localparam int RUN  = 3000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid = 1'b0, iss_use2 = 1'b0, disp_ready = 1'b0, cdb_valid = 1'b0;
   logic [OPW-1:0] iss_op = '0;
   logic [RW-1:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0, rd_addr = '0;
   logic [IMMW-1:0] iss_imm = '0;
   logic [TW-1:0]  cdb_tag = '0;
   logic [DW-1:0]  cdb_value = '0;
   logic iss_stall, disp_valid;
   logic [TW-1:0]  disp_tag, rd_qi;
   logic [OPW-1:0] disp_op;
   logic [DW-1:0]  disp_vj, disp_vk, rd_data;
   logic [IMMW-1:0] disp_imm;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsb_bank #(.NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .OP_W(OPW), .IMM_W(IMMW)) u_rsb_bank (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_use2(iss_use2), .iss_imm(iss_imm),
      .iss_stall(iss_stall), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_tag(disp_tag), .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk),
      .disp_imm(disp_imm), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_qi(rd_qi));

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 1'b0;

   // behavioural model state
   bit              m_busy [NRS];
   bit              m_sent [NRS];
   int              m_qj [NRS];
   int              m_qk [NRS];
   logic [DW-1:0]   m_vj [NRS];
   logic [DW-1:0]   m_vk [NRS];
   logic [OPW-1:0]  m_op [NRS];
   logic [IMMW-1:0] m_imm [NRS];
   logic [DW-1:0]   m_val [NREG];
   int              m_qi [NREG];
   // functional-unit stub queue
   int              f_tag [16];
   logic [DW-1:0]   f_res [16];
   int              f_due [16];
   int              f_head = 0, f_cnt = 0;
   int              stall_seen = 0, bypass_seen = 0;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic logic [DW-1:0] fu(input logic [OPW-1:0] op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b, input logic [IMMW-1:0] im);
      case (op[1:0])
         2'd0: return a + b;
         2'd1: return a - b;
         2'd2: return a + DW'(im);
         default: return a ^ b ^ 32'h5a5a_0001;
      endcase
   endfunction

   task automatic step();
      bit ex_stall, acc, cv_l, by1;
      int dsel, asel, ct, q1, q2;
      logic [DW-1:0] cval, v1, v2;
      logic [DW-1:0] res;
      int slot;
      // result bus from stub
      cv_l = (f_cnt > 0) && (f_due[f_head] == cyc);
      ct   = cv_l ? f_tag[f_head] : 0;
      cval = cv_l ? f_res[f_head] : '0;
      cdb_valid = cv_l;
      cdb_tag   = TW'(ct);
      cdb_value = cval;
      // issue stimulus
      if (cyc < 12) begin
         iss_valid  = 1'b1;
         disp_ready = 1'b0;
      end else if (cyc < RUN) begin
         iss_valid  = ($urandom_range(0, 9) < 6);
         disp_ready = ($urandom_range(0, 9) < 8);
      end else begin
         iss_valid  = 1'b0;
         disp_ready = 1'b1;
      end
      iss_op   = OPW'($urandom_range(0, 15));
      iss_dst  = RW'($urandom_range(0, NREG-1));
      iss_src1 = RW'($urandom_range(0, NREG-1));
      iss_src2 = RW'($urandom_range(0, NREG-1));
      iss_use2 = ($urandom_range(0, 3) != 0);
      iss_imm  = IMMW'($urandom_range(0, 65535));
      rd_addr  = RW'(cyc % NREG);
      #1;
      // expected outputs from model state
      ex_stall = 1'b1;
      for (int i = 0; i < NRS; i++) if (!m_busy[i]) ex_stall = 1'b0;
      dsel = -1;
      for (int i = NRS-1; i >= 0; i--)
         if (m_busy[i] && !m_sent[i] && m_qj[i] == 0 && m_qk[i] == 0) dsel = i;
      check("R3", "iss_stall", 64'(iss_stall), 64'(ex_stall));
      check("R6", "disp_valid", 64'(disp_valid), 64'(dsel >= 0));
      if (dsel >= 0) begin
         check("R6", "disp_tag (lowest ready, R2 numbering)", 64'(disp_tag), 64'(dsel + 1));
         check("R6", "disp_op", 64'(disp_op), 64'(m_op[dsel]));
         check("R5", "disp_vj (R4/R7 operand)", 64'(disp_vj), 64'(m_vj[dsel]));
         check("R11", "disp_vk (R5 operand)", 64'(disp_vk), 64'(m_vk[dsel]));
         check("R10", "disp_imm", 64'(disp_imm), 64'(m_imm[dsel]));
      end
      check("R8", "rd_data", 64'(rd_data), 64'(m_val[cyc % NREG]));
      check("R9", "rd_qi (R2 tag)", 64'(rd_qi), 64'(m_qi[cyc % NREG]));
      if (ex_stall && iss_valid) stall_seen++;
      // next state
      acc  = iss_valid && !ex_stall;
      asel = -1;
      for (int i = NRS-1; i >= 0; i--) if (!m_busy[i]) asel = i;
      q1 = m_qi[iss_src1]; v1 = m_val[iss_src1]; by1 = 1'b0;
      if (q1 != 0) begin
         if (cv_l && ct == q1) begin v1 = cval; q1 = 0; by1 = 1'b1; end
         else v1 = '0;
      end
      q2 = m_qi[iss_src2]; v2 = m_val[iss_src2];
      if (q2 != 0) begin
         if (cv_l && ct == q2) begin v2 = cval; q2 = 0; end
         else v2 = '0;
      end
      if (!iss_use2) begin q2 = 0; v2 = '0; end
      if (acc && by1) bypass_seen++;
      if (cv_l) begin
         for (int i = 0; i < NRS; i++) begin
            if (m_busy[i] && m_qj[i] == ct) begin m_vj[i] = cval; m_qj[i] = 0; end
            if (m_busy[i] && m_qk[i] == ct) begin m_vk[i] = cval; m_qk[i] = 0; end
         end
         m_busy[ct-1] = 1'b0;
         for (int r = 0; r < NREG; r++)
            if (m_qi[r] == ct) begin m_val[r] = cval; m_qi[r] = 0; end
         f_head = (f_head + 1) % 16;
         f_cnt--;
      end
      if (dsel >= 0 && disp_ready) begin
         m_sent[dsel] = 1'b1;
         res  = fu(m_op[dsel], m_vj[dsel], m_vk[dsel], m_imm[dsel]);
         slot = (f_head + f_cnt) % 16;
         f_tag[slot] = dsel + 1;
         f_res[slot] = res;
         f_due[slot] = cyc + LAT;
         f_cnt++;
      end
      if (acc) begin
         m_busy[asel] = 1'b1; m_sent[asel] = 1'b0;
         m_op[asel] = iss_op; m_imm[asel] = iss_imm;
         m_qj[asel] = q1; m_vj[asel] = v1;
         m_qk[asel] = q2; m_vk[asel] = v2;
         m_qi[iss_dst] = asel + 1;
      end
      cyc++;
   endtask

   initial begin
      for (int i = 0; i < NRS; i++) begin
         m_busy[i] = 0; m_sent[i] = 0; m_qj[i] = 0; m_qk[i] = 0;
         m_vj[i] = '0; m_vk[i] = '0; m_op[i] = '0; m_imm[i] = '0;
      end
      for (int r = 0; r < NREG; r++) begin m_val[r] = '0; m_qi[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1", "iss_stall after reset", 64'(iss_stall), 64'd0);
      check("R1", "disp_valid after reset", 64'(disp_valid), 64'd0);
      for (int r = 0; r < NREG; r++) begin
         rd_addr = RW'(r);
         #1;
         check("R1", "register value after reset", 64'(rd_data), 64'd0);
         check("R1", "register tag after reset", 64'(rd_qi), 64'd0);
      end
      while (cyc < RUN + 60) begin
         @(negedge clk);
         step();
      end
      // R3 stall with pending issue and R7 same-cycle bypass must have occurred
      check("R3", "stalled issue attempts seen", 64'(stall_seen > 0), 64'd1);
      check("R7", "same-cycle bypass issues seen", 64'(bypass_seen > 0), 64'd1);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule